// File: doc/BRIEF.md
# Clock Generator Watchdog Control Register

This block holds one 8-bit control register of a programmable clock generator, together with the watchdog timer that the register drives. The register has four fields: a select for the rate of an auxiliary clock output, a watchdog arm/run bit, a timeout flag that software can only read, and a 5-bit safe-frequency code. A plain write strobe with 8-bit data updates the register. The read data port always shows the current contents. Bit 6 reads back whether the countdown is running, not the last value written to it.

Writing 1 to bit 6 loads a down-counter from a programmable timeout input and starts it. The counter then decrements once per pulse of a prescaled tick input. On the tick that brings it to zero, the watchdog stops and sets the timeout flag. If the safe-frequency enable input is high at that moment, the block also sends a one-cycle load strobe with the safe code to the frequency-select field of a separate frequency register, which sits outside this block. Software uses this to force the clock generator back to a known-good frequency when it stops servicing the timer.

Top module: `clkgen_wdog_ctrl`

## Requirements
- R1: After reset, the register reads `{strap_rate_sel, 0, 0, 5'b00010}`, with the strap value present from the first clock after reset release, and `freq_load` is 0.
- R2: Bit 7 is read/write and selects the auxiliary output rate (1 = 24 MHz, 0 = 48 MHz). Until the first write it holds the value of `strap_rate_sel`.
- R3: A write with bit 6 = 1 loads the counter from `timeout_val`, starts the countdown and clears the flag. From the next cycle, bit 6 reads 1 and bit 5 reads 0. A re-arm while the counter is running restarts the count from the full value.
- R4: A write with bit 6 = 0 stops the countdown. Bit 6 then reads 0, the flag keeps its value, and later ticks have no effect.
- R5: While running, each cycle with `tick` = 1 decrements the count. Expiry happens on the N-th tick after arming for `timeout_val` = N ≥ 1, and on the first tick for N = 0. After expiry, bit 6 reads 0 and bit 5 reads 1.
- R6: Bit 5 ignores writes. It is set only by expiry and cleared only by re-arming.
- R7: Bits 4:0 are a read/write safe-frequency code with reset value 5'b00010.
- R8: On expiry with `safe_en` = 1 in the expiring cycle, `freq_load` is 1 for exactly one cycle, in the first cycle in which bit 5 reads 1. In that cycle `freq_code` equals the safe code.
- R9: On expiry with `safe_en` = 0, only the flag is set and `freq_load` stays 0.
- R10: After expiry the counter holds at zero. Further ticks produce no second expiry and no strobe until the watchdog is re-armed.
- R11: A write in the same cycle as a tick takes precedence, so a tick that would expire the counter during a write causes no expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strap_rate_sel | input | 1 | Hardware strap giving the initial value of the rate select |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data: {rate, running, flag, safe code} |
| tick | input | 1 | Prescaled countdown tick, one cycle per count |
| timeout_val | input | CNT_W | Count loaded when the watchdog is armed |
| safe_en | input | 1 | Enables the safe-frequency load on expiry |
| freq_load | output | 1 | One-cycle load strobe to the frequency register |
| freq_code | output | 5 | Code for the frequency-select field |

## Verification
A counter that is off by one moves expiry by one tick. This shows on bit 6 and bit 5 of `rd_data` in the cycle after the tick that should have expired it. A flag that is set or cleared wrongly, or a write priority that is wrong, shows in the read data one cycle after the offending write or tick. A strobe that is missing, repeated or lasts too long, or a wrong stored code, shows on `freq_load`/`freq_code` in the cycle right after expiry, or in the cycle after that. The stimulus runs full countdowns, restarts mid-count, stops the counter, and lines writes up with expiring ticks, so each of these faults surfaces within a few cycles of its cause.

// File: rtl/clkwd_pkg.sv
package clkwd_pkg;
  localparam int REG_W      = 8;
  localparam int CODE_W     = 5;
  localparam int RATE_BIT   = 7;
  localparam int RUN_BIT    = 6;
  localparam int FLAG_BIT   = 5;
  localparam logic [CODE_W-1:0] RESET_CODE = 5'b00010;

  typedef struct packed {
    logic              rate;
    logic              run;
    logic              flag;
    logic [CODE_W-1:0] code;
  } ctrl_view_t;
endpackage

// File: rtl/clkwd_ctrl_reg.sv
module clkwd_ctrl_reg
  import clkwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_rate_sel,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic              rate_sel,
  output logic [CODE_W-1:0] safe_code
);
  logic              strap_pend_q, strap_pend_d;
  logic              rate_q, rate_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              reg_en;

  // Rate field: write wins; otherwise the strap is taken once after reset.
  always_comb begin
    strap_pend_d = 1'b0;
    rate_d       = rate_q;
    code_d       = code_q;
    if (wr_en) begin
      rate_d = wr_data[RATE_BIT];
      code_d = wr_data[CODE_W-1:0];
    end else if (strap_pend_q) begin
      rate_d = strap_rate_sel;
    end
  end

  assign reg_en = wr_en | strap_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_pend_q <= 1'b1;
      rate_q       <= 1'b0;
      code_q       <= RESET_CODE;
    end else if (reg_en) begin
      strap_pend_q <= strap_pend_d;
      rate_q       <= rate_d;
      code_q       <= code_d;
    end
  end

  assign rate_sel  = strap_pend_q ? strap_rate_sel : rate_q;
  assign safe_code = code_q;
endmodule

// File: rtl/clkwd_countdown.sv
module clkwd_countdown #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             halt,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  output logic             running,
  output logic             flag,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             flag_q, flag_d;
  logic             last_cnt;
  logic             cnt_en;

  assign last_cnt = (cnt_q == '0) || (cnt_q == ONE);
  assign expire   = run_q && tick && !arm && !halt && last_cnt;
  assign cnt_en   = arm | halt | (run_q & tick);

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    flag_d = flag_q;
    if (arm) begin
      cnt_d  = load_val;
      run_d  = 1'b1;
      flag_d = 1'b0;
    end else if (halt) begin
      run_d = 1'b0;
    end else if (run_q && tick) begin
      if (last_cnt) begin
        cnt_d  = '0;
        run_d  = 1'b0;
        flag_d = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  assign running = run_q;
  assign flag    = flag_q;
endmodule

// File: rtl/clkwd_fallback.sv
module clkwd_fallback
  import clkwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              safe_en,
  input  logic [CODE_W-1:0] safe_code,
  output logic              freq_load,
  output logic [CODE_W-1:0] freq_code
);
  logic              load_q, load_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              take;

  assign take   = expire & safe_en;
  assign load_d = take;

  always_comb begin
    code_d = code_q;
    if (take) code_d = safe_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
    end else begin
      load_q <= load_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RESET_CODE;
    end else if (take) begin
      code_q <= code_d;
    end
  end

  assign freq_load = load_q;
  assign freq_code = code_q;
endmodule

// File: rtl/clkgen_wdog_ctrl.sv
module clkgen_wdog_ctrl
  import clkwd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_rate_sel,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic             tick,
  input  logic [CNT_W-1:0] timeout_val,
  input  logic             safe_en,
  output logic             freq_load,
  output logic [4:0]       freq_code
);
  logic              rate_sel;
  logic [CODE_W-1:0] safe_code;
  logic              running, flag, expire;
  logic              arm, halt;
  ctrl_view_t        view;

  assign arm  = wr_en &  wr_data[RUN_BIT];
  assign halt = wr_en & ~wr_data[RUN_BIT];

  clkwd_ctrl_reg u_reg (
    .clk            (clk),
    .rst_n          (rst_n),
    .strap_rate_sel (strap_rate_sel),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rate_sel       (rate_sel),
    .safe_code      (safe_code)
  );

  clkwd_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .halt     (halt),
    .tick     (tick),
    .load_val (timeout_val),
    .running  (running),
    .flag     (flag),
    .expire   (expire)
  );

  clkwd_fallback u_fb (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire),
    .safe_en   (safe_en),
    .safe_code (safe_code),
    .freq_load (freq_load),
    .freq_code (freq_code)
  );

  always_comb begin
    view.rate = rate_sel;
    view.run  = running;
    view.flag = flag;
    view.code = safe_code;
  end

  assign rd_data = view;
endmodule

// File: rtl/clkgen_wdog_ctrl_chk.sv
module clkgen_wdog_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       safe_en,
  input logic       freq_load
);
  // R8: strobe lasts a single cycle
  p_load_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    freq_load |=> !freq_load);

  // R8: strobe coincides with a set flag and a stopped counter
  p_load_with_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    freq_load |-> (rd_data[5] && !rd_data[6]));

  // R9: no strobe unless the enable was high at expiry
  p_load_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    freq_load |-> $past(safe_en));

  // R3: arming starts the count and clears the flag
  p_arm_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[6]) |=> (rd_data[6] && !rd_data[5]));

  // R6: a write that does not arm leaves the flag alone
  p_flag_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[6]) |=> (rd_data[5] == $past(rd_data[5])));

  // R7: the code field follows the written data
  p_code_written_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[4:0] == $past(wr_data[4:0])));

  // R10: a stopped watchdog stays put without a write
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[6] && !wr_en) |=> ($stable(rd_data[6:5]) && !freq_load));
endmodule

bind clkgen_wdog_ctrl clkgen_wdog_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .safe_en   (safe_en),
  .freq_load (freq_load)
);

// File: tb/clkgen_wdog_ctrl_bench.sv
module clkgen_wdog_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int NVEC       = 28;

  // {wr_en, wr_data, tick, safe_en, exp_rd, exp_load, exp_code}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b1, 8'hC5, 1'b0, 1'b1, 8'hC5, 1'b0, 5'h00}, //  0 R3 arm, R2 rate=1
    {1'b0, 8'h00, 1'b1, 1'b1, 8'hC5, 1'b0, 5'h00}, //  1 R5 tick 3->2
    {1'b0, 8'h00, 1'b0, 1'b1, 8'hC5, 1'b0, 5'h00}, //  2 R5 no tick
    {1'b0, 8'h00, 1'b1, 1'b1, 8'hC5, 1'b0, 5'h00}, //  3 R5 2->1
    {1'b0, 8'h00, 1'b1, 1'b1, 8'hA5, 1'b1, 5'h05}, //  4 R8 expiry load
    {1'b0, 8'h00, 1'b0, 1'b1, 8'hA5, 1'b0, 5'h00}, //  5 R8 single cycle
    {1'b0, 8'h00, 1'b1, 1'b1, 8'hA5, 1'b0, 5'h00}, //  6 R10 hold at zero
    {1'b1, 8'h0A, 1'b0, 1'b1, 8'h2A, 1'b0, 5'h00}, //  7 R4 R7 R2 flag kept
    {1'b1, 8'h60, 1'b0, 1'b1, 8'h40, 1'b0, 5'h00}, //  8 R3 re-arm clears flag
    {1'b0, 8'h00, 1'b1, 1'b1, 8'h40, 1'b0, 5'h00}, //  9 R5
    {1'b1, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 5'h00}, // 10 R4 halt
    {1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 1'b0, 5'h00}, // 11 R4 tick ignored
    {1'b1, 8'h47, 1'b0, 1'b0, 8'h47, 1'b0, 5'h00}, // 12 R3
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h47, 1'b0, 5'h00}, // 13
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h47, 1'b0, 5'h00}, // 14
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h27, 1'b0, 5'h00}, // 15 R9 flag only
    {1'b0, 8'h00, 1'b0, 1'b1, 8'h27, 1'b0, 5'h00}, // 16 R9
    {1'b1, 8'h47, 1'b0, 1'b1, 8'h47, 1'b0, 5'h00}, // 17 R3
    {1'b0, 8'h00, 1'b1, 1'b1, 8'h47, 1'b0, 5'h00}, // 18
    {1'b1, 8'h47, 1'b0, 1'b1, 8'h47, 1'b0, 5'h00}, // 19 R3 restart mid-count
    {1'b0, 8'h00, 1'b1, 1'b1, 8'h47, 1'b0, 5'h00}, // 20
    {1'b0, 8'h00, 1'b1, 1'b1, 8'h47, 1'b0, 5'h00}, // 21 R3 not yet expired
    {1'b0, 8'h00, 1'b1, 1'b1, 8'h27, 1'b1, 5'h07}, // 22 R8
    {1'b1, 8'h49, 1'b1, 1'b1, 8'h49, 1'b0, 5'h00}, // 23 R3
    {1'b0, 8'h00, 1'b1, 1'b1, 8'h49, 1'b0, 5'h00}, // 24
    {1'b0, 8'h00, 1'b1, 1'b1, 8'h49, 1'b0, 5'h00}, // 25
    {1'b1, 8'h2E, 1'b1, 1'b1, 8'h0E, 1'b0, 5'h00}, // 26 R11 R6 write beats tick
    {1'b0, 8'h00, 1'b1, 1'b1, 8'h0E, 1'b0, 5'h00}  // 27 R11 no late expiry
  };

  logic             clk;
  logic             rst_n;
  logic             strap_rate_sel;
  logic             wr_en;
  logic [7:0]       wr_data;
  logic [7:0]       rd_data;
  logic             tick;
  logic [CNT_W-1:0] timeout_val;
  logic             safe_en;
  logic             freq_load;
  logic [4:0]       freq_code;

  int n_checks;
  int n_fail;
  bit done;

  clkgen_wdog_ctrl #(.CNT_W(CNT_W)) u_clkgen_wdog_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .strap_rate_sel (strap_rate_sel),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rd_data        (rd_data),
    .tick           (tick),
    .timeout_val    (timeout_val),
    .safe_en        (safe_en),
    .freq_load      (freq_load),
    .freq_code      (freq_code)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] exp_rd,
                       input logic exp_load, input logic [4:0] exp_code,
                       input bit chk_code);
    n_checks++;
    if (rd_data !== exp_rd || freq_load !== exp_load ||
        (chk_code && freq_code !== exp_code)) begin
      n_fail++;
      $display("FAIL %s: rd=%02h load=%0b code=%02h expected rd=%02h load=%0b code=%02h",
               req, rd_data, freq_load, freq_code, exp_rd, exp_load, exp_code);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; tick = 1'b0;
    safe_en = 1'b0; strap_rate_sel = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic drive(input logic w, input logic [7:0] d,
                       input logic t, input logic s);
    wr_en = w; wr_data = d; tick = t; safe_en = s;
    @(negedge clk);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 0;
    timeout_val = CNT_W'(3);
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; tick = 1'b0;
    safe_en = 1'b0; strap_rate_sel = 1'b1;

    // R1 R2: reset state with strap high
    do_reset(1'b1);
    check("R1", 8'h82, 1'b0, 5'h02, 1'b1);
    drive(1'b0, 8'h00, 1'b0, 1'b1);
    check("R2", 8'h82, 1'b0, 5'h02, 1'b1);

    // Vector walk
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][24], VEC[i][23:16], VEC[i][15], VEC[i][14]);
      check($sformatf("vector %0d (R2..R11)", i), VEC[i][13:6],
            VEC[i][5], VEC[i][4:0], VEC[i][5]);
    end

    // R5: zero timeout expires on the first tick
    timeout_val = '0;
    drive(1'b1, 8'h41, 1'b0, 1'b1);
    check("R5 arm zero", 8'h41, 1'b0, 5'h00, 1'b0);
    drive(1'b0, 8'h00, 1'b1, 1'b1);
    check("R5 zero expiry R8", 8'h21, 1'b1, 5'h01, 1'b1);
    drive(1'b0, 8'h00, 1'b1, 1'b1);
    check("R10 no re-expiry", 8'h21, 1'b0, 5'h01, 1'b1);

    // R1: reset with strap low
    do_reset(1'b0);
    check("R1 strap low", 8'h02, 1'b0, 5'h02, 1'b1);

    // R2: write overrides strap
    drive(1'b1, 8'h82, 1'b0, 1'b0);
    check("R2 write rate", 8'h82, 1'b0, 5'h02, 1'b1);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule